// File: doc/BRIEF.md
# Triggered Event Readout Sequencer

This block turns each level-1 accept into one event record in a downstream data-acquisition FIFO. On an accept it takes a snapshot of the running bunch-crossing count, the current readout configuration and the next event number. If the event can be stored, the sequencer later emits a four-word header on its output stream. It then runs one front-data block and one processor-data block for each crossing that the configuration asks for. The two block packers are driven through request/grant handshakes. The sequencer hands each packer the crossing number it should pack and waits for its grant before it moves on.

Event numbers advance on every accept, whether the event is kept or not, so a skipped event shows up downstream as a gap in the numbering. Accepts that arrive while an event is being written wait in a small pending queue. An accept is skipped when that queue is full, or when the FIFO's free-space count cannot cover the worst-case size of the new event plus the worst-case sizes of every event already admitted.

The output stream is valid/ready. Once `out_valid` is raised, it stays high and `out_data` holds its value until a cycle with `out_ready` high takes the word. A word transfers on each clock edge where both signals are high. The packer handshakes work as follows. A request stays high with a stable crossing number until the matching grant is sampled high, and the grant marks that packer's block as complete.

Top module: `evt_readout_seq`

## Requirements
- R1: Every header word has 4'hF in bits [15:12]. The first header word carries the configuration as captured at accept: bits [2:0] crossing count, [7:3] front-chip mask, [8] zero-suppression, [9] barrel enable, [11:10] lookup select.
- R2: The four header words go out in a fixed order: configuration, bunch count sampled on the accept cycle, event number bits [11:0], event number bits [23:12].
- R3: The event number starts at 0 after reset and increases by one on every accept, including skipped ones, wrapping at 24 bits.
- R4: An accept is admitted only if `fifo_free` >= R + 4 + 48*N. Here N is its crossing count and R is the sum of 4 + 48*N over all admitted events not yet finished. Otherwise the accept is skipped and nothing of it is ever emitted.
- R5: At most PEND_DEPTH events (default 4) are outstanding, counting the one being written. An event stays outstanding from its accept until its last word or grant, and an accept that arrives while all slots are held is skipped.
- R6: After the header, crossing i (0 <= i < N) raises `fr_req` with `fr_bx` = captured bunch count + i (mod 4096). After `fr_gnt`, it raises `sp_req` with the same value in `sp_bx`. After `sp_gnt`, the next crossing starts or the event ends.
- R7: An event with crossing count 0 emits exactly its four header words and raises no packer request.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle.
- R9: Admitted events are emitted one at a time in accept order. A configuration change after an accept does not alter that event.
- R10: During and right after reset, `out_valid`, `fr_req` and `sp_req` are low.
- R11: At most one of `out_valid`, `fr_req` and `sp_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1a | input | 1 | Level-1 accept strobe, one event per high cycle |
| bx_cnt | input | 12 | Free-running bunch-crossing count |
| cfg_front_mask | input | 5 | Active front-chip mask |
| cfg_barrel_en | input | 1 | Barrel data enable |
| cfg_zsup_en | input | 1 | Zero-suppression enable |
| cfg_lut_sel | input | 2 | Lookup output select, 0 = none |
| cfg_nbx | input | 3 | Crossings per event, 0..7 |
| fifo_free | input | FREE_W | Free words in the downstream FIFO |
| out_valid | output | 1 | Header word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Header word |
| fr_req | output | 1 | Front block request |
| fr_bx | output | 12 | Crossing for the front block |
| fr_gnt | input | 1 | Front block done |
| sp_req | output | 1 | Processor block request |
| sp_bx | output | 12 | Crossing for the processor block |
| sp_gnt | input | 1 | Processor block done |

## Verification
The bench aims at the exact free-space boundary. A fit test that is off by one would drop an event that needs exactly the room left, or admit one that overflows by a single word. It fills the pending queue behind a stalled packer. A wrong full test would then either lose events the queue could hold, or emit more events than the queue has room for and so show numbers the model says were skipped. It also sends crossings that wrap the 12-bit bunch count, events with zero crossings, and a configuration change right after an accept. A design that got these wrong would show a crossing number that fails to wrap, a stray packer request, or a header that carries the new configuration. Random stalls on the output stream check that a held word never changes or vanishes before it is taken.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  localparam int HDR_FIELD_W     = 12;
  localparam int EVN_W           = 2 * HDR_FIELD_W;
  localparam int WORD_W          = 16;
  localparam logic [3:0] HDR_TAG = 4'hF;
  localparam int HDR_WORDS       = 4;
  localparam int FRONT_MAX_WORDS = 32;
  localparam int PROC_MAX_WORDS  = 16;
  localparam int MAX_XING        = 7;
  localparam int XING_WORDS      = FRONT_MAX_WORDS + PROC_MAX_WORDS;
  localparam int EVT_MAX_WORDS   = HDR_WORDS + MAX_XING * XING_WORDS;
  localparam int EVT_SIZE_W      = $clog2(EVT_MAX_WORDS + 1);

  typedef struct packed {
    logic [1:0] lut_sel;
    logic       barrel_en;
    logic       zsup_en;
    logic [4:0] front_mask;
    logic [2:0] nbx;
  } evt_cfg_t;

  typedef struct packed {
    evt_cfg_t                cfg;
    logic [HDR_FIELD_W-1:0]  bx;
    logic [EVN_W-1:0]        num;
  } evt_rec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_FRONT,
    ST_PROC
  } seq_st_t;

  // worst-case word count of one event with nbx crossings
  function automatic logic [EVT_SIZE_W-1:0] evt_worst_words(input logic [2:0] nbx);
    evt_worst_words = EVT_SIZE_W'(HDR_WORDS) +
                      EVT_SIZE_W'(nbx) * EVT_SIZE_W'(XING_WORDS);
  endfunction
endpackage

// File: rtl/evt_pend_queue.sv
module evt_pend_queue
  import evt_seq_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  evt_rec_t         push_rec,
  input  logic             pop,
  output evt_rec_t         head_rec,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  evt_rec_t         slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    ptr_next = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign head_rec = slot_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_push && (wr_ptr_q == PTR_W'(i))) slot_q[i] <= push_rec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/evt_admit.sv
module evt_admit
  import evt_seq_pkg::*;
#(
  parameter int FREE_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   l1a,
  input  logic [HDR_FIELD_W-1:0] bx_cnt,
  input  evt_cfg_t               cfg_in,
  input  logic [FREE_W-1:0]      fifo_free,
  input  logic                   q_full,
  input  logic                   retire,
  input  logic [2:0]             retire_nbx,
  output logic                   push,
  output evt_rec_t               push_rec
);
  localparam int RSV_W = $clog2(DEPTH * EVT_MAX_WORDS + 1);
  localparam int CMP_W = ((FREE_W > RSV_W) ? FREE_W : RSV_W) + 1;

  logic [EVN_W-1:0]      evn_q;
  logic [RSV_W-1:0]      rsv_q;
  logic [EVT_SIZE_W-1:0] need_words, drop_words;
  logic [CMP_W-1:0]      want_words;
  logic                  fits;

  assign need_words = evt_worst_words(cfg_in.nbx);
  assign drop_words = evt_worst_words(retire_nbx);
  assign want_words = CMP_W'(rsv_q) + CMP_W'(need_words);
  assign fits       = CMP_W'(fifo_free) >= want_words;
  assign push       = l1a && fits && !q_full;

  always_comb begin
    push_rec.cfg = cfg_in;
    push_rec.bx  = bx_cnt;
    push_rec.num = evn_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evn_q <= '0;
      rsv_q <= '0;
    end else begin
      if (l1a) evn_q <= evn_q + EVN_W'(1);
      rsv_q <= rsv_q
             + (push   ? RSV_W'(need_words) : RSV_W'(0))
             - (retire ? RSV_W'(drop_words) : RSV_W'(0));
    end
  end
endmodule

// File: rtl/evt_emit_fsm.sv
module evt_emit_fsm
  import evt_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   head_valid,
  input  evt_rec_t               head_rec,
  output logic                   out_valid,
  output logic [WORD_W-1:0]      out_data,
  input  logic                   out_ready,
  output logic                   fr_req,
  output logic [HDR_FIELD_W-1:0] fr_bx,
  input  logic                   fr_gnt,
  output logic                   sp_req,
  output logic [HDR_FIELD_W-1:0] sp_bx,
  input  logic                   sp_gnt,
  output logic                   retire
);
  seq_st_t                st_q, st_d;
  logic [1:0]             hidx_q, hidx_d;
  logic [2:0]             xidx_q, xidx_d;
  logic [HDR_FIELD_W-1:0] hdr_field, xing_bx;
  logic                   last_xing;

  always_comb begin
    case (hidx_q)
      2'd0:    hdr_field = head_rec.cfg;
      2'd1:    hdr_field = head_rec.bx;
      2'd2:    hdr_field = head_rec.num[HDR_FIELD_W-1:0];
      default: hdr_field = head_rec.num[EVN_W-1:HDR_FIELD_W];
    endcase
  end

  assign out_data  = {HDR_TAG, hdr_field};
  assign out_valid = (st_q == ST_HDR);
  assign xing_bx   = head_rec.bx + HDR_FIELD_W'(xidx_q);
  assign fr_req    = (st_q == ST_FRONT);
  assign sp_req    = (st_q == ST_PROC);
  assign fr_bx     = xing_bx;
  assign sp_bx     = xing_bx;
  assign last_xing = (xidx_q == (head_rec.cfg.nbx - 3'd1));

  always_comb begin
    st_d   = st_q;
    hidx_d = hidx_q;
    xidx_d = xidx_q;
    retire = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (head_valid) begin
          st_d   = ST_HDR;
          hidx_d = 2'd0;
          xidx_d = 3'd0;
        end
      end
      ST_HDR: begin
        if (out_ready) begin
          if (hidx_q == 2'd3) begin
            if (head_rec.cfg.nbx == 3'd0) begin
              retire = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              st_d = ST_FRONT;
            end
          end else begin
            hidx_d = hidx_q + 2'd1;
          end
        end
      end
      ST_FRONT: begin
        if (fr_gnt) st_d = ST_PROC;
      end
      ST_PROC: begin
        if (sp_gnt) begin
          if (last_xing) begin
            retire = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            xidx_d = xidx_q + 3'd1;
            st_d   = ST_FRONT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hidx_q <= 2'd0;
      xidx_q <= 3'd0;
    end else begin
      st_q   <= st_d;
      hidx_q <= hidx_d;
      xidx_q <= xidx_d;
    end
  end
endmodule

// File: rtl/evt_readout_seq.sv
module evt_readout_seq
  import evt_seq_pkg::*;
#(
  parameter int FREE_W     = 12,
  parameter int PEND_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   l1a,
  input  logic [HDR_FIELD_W-1:0] bx_cnt,
  input  logic [4:0]             cfg_front_mask,
  input  logic                   cfg_barrel_en,
  input  logic                   cfg_zsup_en,
  input  logic [1:0]             cfg_lut_sel,
  input  logic [2:0]             cfg_nbx,
  input  logic [FREE_W-1:0]      fifo_free,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   fr_req,
  output logic [HDR_FIELD_W-1:0] fr_bx,
  input  logic                   fr_gnt,
  output logic                   sp_req,
  output logic [HDR_FIELD_W-1:0] sp_bx,
  input  logic                   sp_gnt
);
  localparam int PEND_CNT_W = $clog2(PEND_DEPTH + 1);

  evt_cfg_t              cfg_now;
  evt_rec_t              push_rec, head_rec;
  logic                  push, retire, q_full, q_empty;
  logic [PEND_CNT_W-1:0] pend_cnt;

  always_comb begin
    cfg_now.lut_sel    = cfg_lut_sel;
    cfg_now.barrel_en  = cfg_barrel_en;
    cfg_now.zsup_en    = cfg_zsup_en;
    cfg_now.front_mask = cfg_front_mask;
    cfg_now.nbx        = cfg_nbx;
  end

  evt_admit #(.FREE_W(FREE_W), .DEPTH(PEND_DEPTH)) admit_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .l1a        (l1a),
    .bx_cnt     (bx_cnt),
    .cfg_in     (cfg_now),
    .fifo_free  (fifo_free),
    .q_full     (q_full),
    .retire     (retire),
    .retire_nbx (head_rec.cfg.nbx),
    .push       (push),
    .push_rec   (push_rec)
  );

  evt_pend_queue #(.DEPTH(PEND_DEPTH)) queue_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_rec (push_rec),
    .pop      (retire),
    .head_rec (head_rec),
    .count    (pend_cnt),
    .full     (q_full),
    .empty    (q_empty)
  );

  evt_emit_fsm emit_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (!q_empty),
    .head_rec   (head_rec),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .fr_req     (fr_req),
    .fr_bx      (fr_bx),
    .fr_gnt     (fr_gnt),
    .sp_req     (sp_req),
    .sp_bx      (sp_bx),
    .sp_gnt     (sp_gnt),
    .retire     (retire)
  );
endmodule

// File: rtl/evt_readout_seq_chk.sv
module evt_readout_seq_chk #(
  parameter int PEND_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic             fr_req,
  input logic [11:0]      fr_bx,
  input logic             fr_gnt,
  input logic             sp_req,
  input logic [11:0]      sp_bx,
  input logic [CNT_W-1:0] pend_cnt
);
  // R1: header words carry the tag nibble
  assert_tag_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[15:12] == 4'hF);

  // R8: a stalled word is held unchanged
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: front request stays up with a stable crossing until granted
  assert_front_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_req && !fr_gnt |=> fr_req && $stable(fr_bx));

  // R6: processor block follows the front block of the same crossing
  assert_pair_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fr_req && fr_gnt |=> sp_req && sp_bx == $past(fr_bx));

  // R11: one phase at a time
  assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, fr_req, sp_req}));

  // R5: outstanding events never exceed the queue depth
  assert_pend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CNT_W'(PEND_DEPTH));

  // R9: activity only while an admitted event is outstanding
  assert_work_has_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || fr_req || sp_req) |-> pend_cnt != '0);
endmodule

bind evt_readout_seq evt_readout_seq_chk #(
  .PEND_DEPTH (PEND_DEPTH),
  .CNT_W      (PEND_CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fr_req    (fr_req),
  .fr_bx     (fr_bx),
  .fr_gnt    (fr_gnt),
  .sp_req    (sp_req),
  .sp_bx     (sp_bx),
  .pend_cnt  (pend_cnt)
);

// File: tb/evt_readout_seq_tb_top.sv
`timescale 1ns/100ps
module evt_readout_seq_tb_top;
  localparam int FREE_W     = 12;
  localparam int PEND_DEPTH = 4;

  logic        clk = 1'b0, rst_n = 1'b0, l1a = 1'b0;
  logic [11:0] bx_cnt = '0;
  logic [4:0]  cfg_front_mask = '0;
  logic        cfg_barrel_en = 1'b0, cfg_zsup_en = 1'b0;
  logic [1:0]  cfg_lut_sel = '0;
  logic [2:0]  cfg_nbx = '0;
  logic [FREE_W-1:0] fifo_free = '1;
  logic        out_ready = 1'b1, fr_gnt = 1'b0, sp_gnt = 1'b0;
  logic        out_valid, fr_req, sp_req;
  logic [15:0] out_data;
  logic [11:0] fr_bx, sp_bx;

  always #2.5 clk = ~clk;

  evt_readout_seq #(.FREE_W(FREE_W), .PEND_DEPTH(PEND_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .l1a(l1a), .bx_cnt(bx_cnt),
    .cfg_front_mask(cfg_front_mask), .cfg_barrel_en(cfg_barrel_en),
    .cfg_zsup_en(cfg_zsup_en), .cfg_lut_sel(cfg_lut_sel), .cfg_nbx(cfg_nbx),
    .fifo_free(fifo_free), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fr_req(fr_req), .fr_bx(fr_bx), .fr_gnt(fr_gnt),
    .sp_req(sp_req), .sp_bx(sp_bx), .sp_gnt(sp_gnt)
  );

  typedef struct { int bx; int num; int cfg; } mrec_t;
  mrec_t mq[$];
  int m_evn = 0, m_hidx = 0, m_xidx = 0, m_drops = 0, m_fr_done = 0;
  int vectors = 0, fails = 0, last_num = -1, n_fire = 0;
  int fr_delay = 0, sp_delay = 0, fr_wait = 0, sp_wait = 0, ready_mode = 0, bx_load = -1;
  bit hold = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int cur_cfg();
    return int'({cfg_lut_sel, cfg_barrel_en, cfg_zsup_en, cfg_front_mask, cfg_nbx});
  endfunction

  function automatic int exp_hdr(mrec_t r, int idx);
    case (idx)
      0:       return 'hF000 | r.cfg;
      1:       return 'hF000 | r.bx;
      2:       return 'hF000 | (r.num & 'hFFF);
      default: return 'hF000 | ((r.num >> 12) & 'hFFF);
    endcase
  endfunction

  // behavioural reference, evaluated just before each rising edge
  always @(negedge clk) begin : mdl
    bit    do_push;
    mrec_t nr;
    int    rsv, exp, nbx;
    #2;
    if (rst_n) begin
      do_push = 1'b0;
      if (out_valid || fr_req || sp_req)
        chk($onehot0({out_valid, fr_req, sp_req}), "R11", "phases exclusive",
            {out_valid, fr_req, sp_req}, 0);
      if (l1a) begin
        rsv = 0;
        foreach (mq[i]) rsv += 4 + 48 * (mq[i].cfg & 7);
        nr.cfg = cur_cfg();
        nr.bx  = int'(bx_cnt);
        nr.num = m_evn;
        m_evn  = (m_evn + 1) & 'hFFFFFF;
        if (mq.size() < PEND_DEPTH && int'(fifo_free) >= rsv + 4 + 48 * (nr.cfg & 7))
          do_push = 1'b1;
        else
          m_drops++;
      end
      if ((fr_req || sp_req) && (mq.size() == 0 || m_hidx != 4))
        chk(1'b0, "R7", "packer request outside crossing phase", {fr_req, sp_req}, 0);
      if (out_valid && out_ready) begin
        if (mq.size() == 0 || m_hidx >= 4)
          chk(1'b0, "R9", "header word with no event due", out_data, 0);
        else begin
          exp = exp_hdr(mq[0], m_hidx);
          chk(int'(out_data) == exp,
              (m_hidx == 0) ? "R1" : (m_hidx == 1) ? "R2" : "R3",
              "header word", out_data, exp);
          if (m_hidx == 2) last_num = int'(out_data[11:0]);
          if (m_hidx == 3) last_num = last_num | (int'(out_data[11:0]) << 12);
          m_hidx++;
          if (m_hidx == 4 && (mq[0].cfg & 7) == 0) begin
            void'(mq.pop_front());
            m_hidx = 0;
          end
        end
      end
      if (fr_req && fr_gnt && mq.size() != 0 && m_hidx == 4) begin
        exp = (mq[0].bx + m_xidx) & 'hFFF;
        chk(m_fr_done == 0, "R6", "front block repeated", m_fr_done, 0);
        chk(int'(fr_bx) == exp, "R6", "front crossing", fr_bx, exp);
        m_fr_done = 1;
      end
      if (sp_req && sp_gnt && mq.size() != 0 && m_hidx == 4) begin
        exp = (mq[0].bx + m_xidx) & 'hFFF;
        nbx = mq[0].cfg & 7;
        chk(m_fr_done == 1, "R6", "processor block before front", m_fr_done, 1);
        chk(int'(sp_bx) == exp, "R6", "processor crossing", sp_bx, exp);
        m_fr_done = 0;
        m_xidx++;
        if (m_xidx == nbx) begin
          void'(mq.pop_front());
          m_hidx = 0;
          m_xidx = 0;
        end
      end
      if (do_push) mq.push_back(nr);
    end
  end

  // packer responders, ready pattern and free-running bunch count
  always @(negedge clk) begin
    if (!rst_n) begin
      fr_gnt = 1'b0; sp_gnt = 1'b0; fr_wait = 0; sp_wait = 0;
    end else begin
      if (fr_gnt) begin fr_gnt = 1'b0; fr_wait = 0; end
      else if (fr_req && !hold) begin
        if (fr_wait >= fr_delay) fr_gnt = 1'b1; else fr_wait++;
      end
      if (sp_gnt) begin sp_gnt = 1'b0; sp_wait = 0; end
      else if (sp_req && !hold) begin
        if (sp_wait >= sp_delay) sp_gnt = 1'b1; else sp_wait++;
      end
      out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
    if (bx_load >= 0) begin bx_cnt = 12'(bx_load); bx_load = -1; end
    else bx_cnt = bx_cnt + 12'd1;
  end

  task automatic fire(input int nbx, input int mask, input int zs, input int br, input int lut);
    @(negedge clk);
    cfg_nbx = 3'(nbx); cfg_front_mask = 5'(mask); cfg_zsup_en = 1'(zs);
    cfg_barrel_en = 1'(br); cfg_lut_sel = 2'(lut); l1a = 1'b1;
    n_fire++;
    @(negedge clk);
    l1a = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t;
    t = 0;
    while (mq.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    #1;
    chk(mq.size() == 0, tag, "events left unfinished", mq.size(), 0);
    chk(!out_valid && !fr_req && !sp_req, tag, "idle after event",
        {out_valid, fr_req, sp_req}, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !fr_req && !sp_req, "R10", "outputs in reset", {out_valid, fr_req, sp_req}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && !fr_req && !sp_req, "R10", "outputs after reset", {out_valid, fr_req, sp_req}, 0);

    // R7 and first number R3
    fire(0, 'h1F, 1, 1, 2);
    wait_idle("R7");
    chk(last_num == 0, "R3", "first event number", last_num, 0);

    // R6 several crossings, packer delays
    fr_delay = 2; sp_delay = 0;
    fire(3, 'h0A, 0, 1, 1);
    wait_idle("R6");
    fr_delay = 0; sp_delay = 3;
    fire(2, 'h15, 1, 0, 3);
    wait_idle("R6");

    // R6 crossing numbers wrap the 12-bit count
    sp_delay = 0; bx_load = 4093;
    fire(7, 'h11, 0, 0, 0);
    wait_idle("R6");

    // R8 back-pressure
    ready_mode = 1;
    fire(2, 'h03, 1, 1, 1);
    fire(1, 'h1C, 0, 1, 2);
    fire(0, 'h07, 1, 0, 3);
    wait_idle("R8");
    ready_mode = 0;

    // R4 exact fit boundary
    fifo_free = 12'd100; d0 = m_drops;
    fire(2, 'h01, 0, 0, 0);
    fire(3, 'h02, 0, 0, 0);
    wait_idle("R4");
    chk(m_drops - d0 == 1, "R4", "skips with reservation", m_drops - d0, 1);
    fifo_free = 12'd99; d0 = m_drops;
    fire(2, 'h04, 0, 0, 0);
    wait_idle("R4");
    chk(m_drops - d0 == 1, "R4", "skip one word short", m_drops - d0, 1);
    fire(0, 'h04, 0, 0, 0);
    wait_idle("R4");
    chk(last_num == n_fire - 1, "R3", "number after skips", last_num, n_fire - 1);
    fifo_free = '1;

    // R5 pending queue full behind a stalled packer
    hold = 1'b1; d0 = m_drops;
    repeat (6) fire(1, 'h1F, 0, 1, 0);
    repeat (5) @(negedge clk);
    #1;
    chk(fr_req == 1'b1, "R5", "front stalled", fr_req, 1);
    chk(m_drops - d0 == 2, "R5", "skips when queue full", m_drops - d0, 2);
    hold = 1'b0;
    wait_idle("R5");

    // R9 config changes right after accept
    fire(2, 'h09, 1, 0, 1);
    fire(1, 'h16, 0, 1, 2);
    cfg_nbx = 3'd5; cfg_front_mask = 5'h1F; cfg_lut_sel = 2'd3;
    wait_idle("R9");

    // random traffic
    for (int k = 0; k < 40; k++) begin
      ready_mode = int'($urandom % 2);
      fr_delay   = int'($urandom % 4);
      sp_delay   = int'($urandom % 4);
      fifo_free  = FREE_W'(60 + ($urandom % 700));
      fire(int'($urandom % 8), int'($urandom % 32), int'($urandom % 2),
           int'($urandom % 2), int'($urandom % 4));
      repeat ($urandom % 20) @(negedge clk);
    end
    fifo_free = '1; ready_mode = 0;
    wait_idle("R9");

    fire(0, 'h00, 0, 0, 0);
    wait_idle("R3");
    chk(last_num == n_fire - 1, "R3", "number counts every accept", last_num, n_fire - 1);

    summary();
    $finish;
  end
endmodule